// File: doc/BRIEF.md
# Iterative LSB-First Magnitude Comparator

This block compares two unsigned operands of a configurable width and raises exactly one of three verdict lines: greater, equal or less. It is purely combinational, with no clock and no reset, and is meant to sit inside a larger datapath wherever two unsigned values must be ordered.

The verdict is formed by a chain of identical one-bit cells. The cell at bit 0 receives a fixed seed (not greater, equal, not less). Every cell looks at its own pair of bits. Where the bits differ, it replaces the verdict from below. Where they match, it passes that verdict upward unchanged. The verdict leaving the most significant cell is the block result. A parameter chooses how each cell forms its "less" line. It can compute it directly from the bits, or derive it as the complement of "greater or equal".

Top module: `magcmp_lsb_chain`

## Requirements
- R1: For every operand pair, exactly one of `gt_o`, `eq_o`, `lt_o` is 1 and the other two are 0.
- R2: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both read as unsigned integers.
- R3: `eq_o` is 1 exactly when `a_i` and `b_i` are identical in every bit.
- R4: `lt_o` is 1 exactly when `a_i` is less than `b_i`, with both read as unsigned integers.
- R5: A difference at a higher bit position decides the verdict whatever the lower bits hold. For example, with WIDTH=4, a_i=1000 and b_i=0111 gives `gt_o`=1.
- R6: A cell whose two bits are equal passes the verdict from the bits below it upward unchanged. So when the operands differ only in bit 0, the verdict follows bit 0 alone.
- R7: The chain starts from the seed greater=0, equal=1, less=0. With WIDTH=1 the block is a single cell fed by that seed and still meets R1 to R4.
- R8: With LT_DERIVED=1, where each cell forms its less line as NOT(greater OR equal), all three outputs match those produced with LT_DERIVED=0 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when a_i is greater than b_i |
| eq_o | output | 1 | High when a_i equals b_i |
| lt_o | output | 1 | High when a_i is less than b_i |

## Verification
Two functions of the chain meet in a single evaluation. A low-order cell sets a verdict, and a higher-order cell with differing bits overrides it in the opposite direction. The bench provokes this with operand pairs that differ at two or more positions in conflicting directions, such as a low bit favouring one operand and a high bit favouring the other. The exhaustive 4-bit sweep and the random 16-bit pairs both contain many such cases. Each verdict is judged against the unsigned relational operators evaluated in the bench. The bench also compares the directly computed and the derived variants of the less line against each other over every 4-bit pair.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Verdict carried between cells, one bit per relation.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

  // Value fed below bit 0: nothing seen yet, so operands are equal so far.
  localparam verdict_t VERDICT_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  // Bit match term: both ones or both zeros.
  function automatic logic bit_match(input logic x, input logic y);
    return (x & y) | (~x & ~y);
  endfunction

  // This bit alone says first operand is larger.
  function automatic logic bit_above(input logic x, input logic y);
    return x & ~y;
  endfunction

  // This bit alone says first operand is smaller.
  function automatic logic bit_below(input logic x, input logic y);
    return ~x & y;
  endfunction

endpackage

// File: rtl/magcmp_cell.sv
module magcmp_cell
  import magcmp_pkg::*;
#(
  parameter bit LT_DERIVED = 1'b0
) (
  input  logic     a_bit,
  input  logic     b_bit,
  input  verdict_t prev_v,
  output verdict_t next_v
);

  // Named internal events, visible to the assertions below.
  logic same_w;
  logic win_w;
  logic lose_w;
  logic gt_w;
  logic eq_w;
  logic lt_w;

  always_comb begin
    same_w = bit_match(a_bit, b_bit);
    win_w  = bit_above(a_bit, b_bit);
    lose_w = bit_below(a_bit, b_bit);
    gt_w   = win_w | (same_w & prev_v.gt);
    eq_w   = same_w & prev_v.eq;
  end

  generate
    if (LT_DERIVED) begin : g_lt_derived
      always_comb lt_w = ~(gt_w | eq_w);
    end else begin : g_lt_direct
      always_comb lt_w = lose_w | (same_w & prev_v.lt);
    end
  endgenerate

  always_comb begin
    next_v.gt = gt_w;
    next_v.eq = eq_w;
    next_v.lt = lt_w;

    // A single well-formed verdict in yields a single well-formed verdict out.
    if ($countones(prev_v) == 1)
      AST_ONE_HOT_KEPT: assert ($countones({gt_w, eq_w, lt_w}) == 1); // R1
    // Matching bits leave the lower verdict untouched.
    if (a_bit == b_bit)
      AST_MATCH_PASSES: assert ({gt_w, eq_w, lt_w} == prev_v); // R6
    // A 1 over 0 at this cell overrides anything from below.
    if (a_bit && !b_bit)
      AST_HIGH_WINS_GT: assert (gt_w && !eq_w && !lt_w); // R5
    // A 0 under 1 at this cell overrides anything from below.
    if (!a_bit && b_bit && ($countones(prev_v) == 1))
      AST_HIGH_WINS_LT: assert (lt_w && !gt_w && !eq_w); // R5
  end

endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter bit          LT_DERIVED = 1'b0
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  output verdict_t         final_v
);

  localparam int unsigned LINKS = WIDTH + 1;

  // links[k] is the verdict entering cell k; links[WIDTH] leaves the top cell.
  verdict_t links [LINKS];

  assign links[0] = VERDICT_SEED; // R7

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
      magcmp_cell #(
        .LT_DERIVED(LT_DERIVED)
      ) u_cell (
        .a_bit (a_vec[k]),
        .b_bit (b_vec[k]),
        .prev_v(links[k]),
        .next_v(links[k+1])
      );
    end
  endgenerate

  assign final_v = links[WIDTH];

endmodule

// File: rtl/magcmp_lsb_chain.sv
module magcmp_lsb_chain
  import magcmp_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter bit          LT_DERIVED = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);

  verdict_t result_v;

  magcmp_chain #(
    .WIDTH     (WIDTH),
    .LT_DERIVED(LT_DERIVED)
  ) u_chain (
    .a_vec  (a_i),
    .b_vec  (b_i),
    .final_v(result_v)
  );

  assign gt_o = result_v.gt;
  assign eq_o = result_v.eq;
  assign lt_o = result_v.lt;

endmodule

// File: tb/magcmp_lsb_chain_test.sv
module magcmp_lsb_chain_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [3:0]  a4, b4;
  logic [0:0]  a1, b1;
  logic [15:0] a16, b16;
  logic gt4, eq4, lt4, gtd, eqd, ltd, gt1, eq1, lt1, gt16, eq16, lt16;

  magcmp_lsb_chain #(.WIDTH(4), .LT_DERIVED(1'b0)) uut (
    .a_i(a4), .b_i(b4), .gt_o(gt4), .eq_o(eq4), .lt_o(lt4));
  magcmp_lsb_chain #(.WIDTH(4), .LT_DERIVED(1'b1)) uut_d (
    .a_i(a4), .b_i(b4), .gt_o(gtd), .eq_o(eqd), .lt_o(ltd));
  magcmp_lsb_chain #(.WIDTH(1), .LT_DERIVED(1'b0)) uut_w1 (
    .a_i(a1), .b_i(b1), .gt_o(gt1), .eq_o(eq1), .lt_o(lt1));
  magcmp_lsb_chain #(.WIDTH(16), .LT_DERIVED(1'b0)) uut_w16 (
    .a_i(a16), .b_i(b16), .gt_o(gt16), .eq_o(eq16), .lt_o(lt16));

  // Expected verdict {gt,eq,lt} from the language's unsigned operators.
  function automatic logic [2:0] expect_v(input longint unsigned x, input longint unsigned y);
    return {x > y, x == y, x < y};
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp_v);
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: got gt/eq/lt=%b expected=%b", req, got, exp_v);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] x, input logic [15:0] y);
    @(posedge clk);
    a16 = x; b16 = y;
    @(negedge clk);
    check(req, {gt16, eq16, lt16}, expect_v(x, y));
    check("R1 one-hot w16", 3'($countones({gt16, eq16, lt16})), 3'd1);
  endtask

  initial begin
    a4 = '0; b4 = '0; a1 = '0; b1 = '0; a16 = '0; b16 = '0;
    void'($urandom(32'd2024));
    @(negedge clk);
    // Idle state: zero operands give the seed verdict.
    check("R7 zero operands", {gt4, eq4, lt4}, 3'b010);

    // Exhaustive 4-bit sweep, both less-line variants.
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        a4 = 4'(i); b4 = 4'(j);
        @(negedge clk);
        if (i > j)       check("R2 gt 4-bit", {gt4, eq4, lt4}, expect_v(i, j));
        else if (i == j) check("R3 eq 4-bit", {gt4, eq4, lt4}, expect_v(i, j));
        else             check("R4 lt 4-bit", {gt4, eq4, lt4}, expect_v(i, j));
        check("R1 one-hot 4-bit", 3'($countones({gt4, eq4, lt4})), 3'd1);
        check("R8 derived lt matches", {gtd, eqd, ltd}, {gt4, eq4, lt4});
      end
    end

    // Directed 4-bit: high bit override and low-bit-only difference.
    @(posedge clk); a4 = 4'b1000; b4 = 4'b0111;
    @(negedge clk); check("R5 msb override gt", {gt4, eq4, lt4}, 3'b100);
    @(posedge clk); a4 = 4'b0111; b4 = 4'b1000;
    @(negedge clk); check("R5 msb override lt", {gt4, eq4, lt4}, 3'b001);
    @(posedge clk); a4 = 4'b1010; b4 = 4'b1011;
    @(negedge clk); check("R6 low bit decides", {gt4, eq4, lt4}, 3'b001);
    @(posedge clk); a4 = 4'b0101; b4 = 4'b0100;
    @(negedge clk); check("R6 low bit decides", {gt4, eq4, lt4}, 3'b100);

    // Single-cell chain, every pair.
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        @(posedge clk);
        a1 = 1'(i); b1 = 1'(j);
        @(negedge clk);
        check("R7 width one", {gt1, eq1, lt1}, expect_v(i, j));
      end
    end

    // 16-bit directed corners.
    run16("R3 eq w16 all ones", 16'hFFFF, 16'hFFFF);
    run16("R4 lt w16 zero vs max", 16'h0000, 16'hFFFF);
    run16("R2 gt w16 max vs zero", 16'hFFFF, 16'h0000);
    run16("R5 w16 msb override", 16'h8000, 16'h7FFF);
    run16("R6 w16 bit0 only", 16'hA5A4, 16'hA5A5);

    // 16-bit random, with a share of near-equal pairs.
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = (n % 4 == 0) ? (x ^ 16'(1 << ($urandom % 16))) : 16'($urandom);
      if (n % 50 == 0) y = x;
      run16("R2/R3/R4 w16 random", x, y);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule